// File: doc/BRIEF.md
# Banked Memory Protection Region Checker

This block holds a table of memory-protection region descriptors and judges every access address against them. Software fills the table through a small word-addressed register port. The port shows only sixteen descriptor pairs at a time, and a bank field in a control register chooses which group of sixteen those pairs refer to. A region's global index is its bank times sixteen plus its slot within the window.

For each access request, the block compares the address with every valid region in parallel. It picks the matching region with the lowest global index. It then decides from that region's permission bits whether the access kind is allowed, and reports the region's cacheability and volatility flags. The verdict is registered, so it appears one clock after the request. When checking is switched off, or no region matches, the block reports a miss and applies a fixed fallback: kernel accesses pass and user accesses are refused.

Top module: `mpr_region_guard`

## Requirements
- R1: Window offset 2k is the base word of slot k and offset 2k+1 is its permission word, for k = 0..15. Offset 32 is the control word. A read of any offset returns the stored word of the currently selected bank, or the control bits for offset 32.
- R2: Control bit 0 selects the bank. Slot writes and reads reach only global region bank*16+slot, so the other bank's descriptor at the same slot is left unchanged.
- R3: The size code is {perm[11:9], perm[1:0]}. Code N covers 2^(N+1) bytes. Codes 0 to 3 behave as code 4 (32 bytes), and code 31 covers the whole 32-bit address space.
- R4: Base bit 0 is the valid flag, and a region with this flag clear never matches. An address matches a valid region of code N when address bits [31:N+1] equal base bits [31:N+1]. Base bits below the region size are ignored.
- R5: When several regions match, the result reports the lowest global index.
- R6: On a hit, the access is allowed as follows: a user read needs perm[5], a user write needs perm[4], a kernel read needs perm[8], and a kernel write needs perm[7]. Bits perm[3] and perm[6] have no effect on the verdict.
- R7: Control bit 30 enables checking. While it is clear, every access reports a miss.
- R8: On a miss, the region index and all flags read 0, and the access is allowed exactly when it is a kernel access.
- R9: On a hit, the code-uncached flag is perm[12], the data-uncached flag is perm[13], and the non-volatile flag is perm[14].
- R10: Every result output changes one clock after a request. The result-valid output is high exactly in the cycle after a cycle with the request input high.
- R11: Reset clears all descriptor words, the enable bit and the bank field, and all result outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| acc_req | input | 1 | Access check request |
| acc_addr | input | 32 | Access address |
| acc_user | input | 1 | 1 = user access, 0 = kernel access |
| acc_write | input | 1 | 1 = write, 0 = read |
| res_valid | output | 1 | Result valid, one cycle after acc_req |
| res_hit | output | 1 | A valid enabled region matched |
| res_region | output | 5 | Global index of the deciding region |
| res_allow | output | 1 | Access permitted |
| res_nc_code | output | 1 | Deciding region marks code uncached |
| res_nc_data | output | 1 | Deciding region marks data uncached |
| res_nv | output | 1 | Deciding region is non-volatile |

## Verification
Several properties are checked on every cycle. The result-valid output must follow the request by exactly one clock. A disabled block must never report a hit. A miss must always fall back to the kernel-only policy. A reported region must have matched and must have had no lower-indexed match, and a control write must land in the bank field. The bench alone can show the size decoding at region edges, the clamping of reserved codes, the whole-space code, and the per-kind permission bits. It also shows the isolation between banks and the flag reporting, all by comparing against a bench-side model over random descriptor tables.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
   localparam int BASE_VALID_BIT = 0;
   localparam int PERM_UW_BIT    = 4;
   localparam int PERM_UR_BIT    = 5;
   localparam int PERM_KW_BIT    = 7;
   localparam int PERM_KR_BIT    = 8;
   localparam int PERM_NCC_BIT   = 12;
   localparam int PERM_NCD_BIT   = 13;
   localparam int PERM_NV_BIT    = 14;
   localparam int CTRL_EN_BIT    = 30;
   localparam int SIZE_CODE_MIN  = 4;

   typedef struct packed {
      logic hit;
      logic allow;
      logic nc_code;
      logic nc_data;
      logic nv;
   } mpr_verdict_t;
endpackage

// File: rtl/mpr_desc_store.sv
module mpr_desc_store #(
   parameter int AW        = 32,
   parameter int SLOTS     = 16,
   parameter int NUM_BANKS = 2,
   localparam int NREG     = SLOTS * NUM_BANKS,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int CFG_AW   = SLOT_W + 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [CFG_AW-1:0]         cfg_addr,
   input  logic [AW-1:0]             cfg_wdata,
   output logic [AW-1:0]             cfg_rdata,
   output logic [NREG-1:0][AW-1:0]   base_q,
   output logic [NREG-1:0][AW-1:0]   perm_q,
   output logic                      en_q
);
   import mpr_pkg::*;

   logic [BANK_W-1:0]       bank_q;
   logic                    is_ctrl;
   logic                    sel_perm;
   logic [SLOT_W+BANK_W-1:0] gidx;

   assign is_ctrl  = cfg_addr[CFG_AW-1];
   assign sel_perm = cfg_addr[0];
   assign gidx     = {bank_q, cfg_addr[SLOT_W:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         perm_q <= '0;
         en_q   <= 1'b0;
         bank_q <= '0;
      end else if (cfg_we) begin
         if (is_ctrl) begin
            en_q   <= cfg_wdata[CTRL_EN_BIT];
            bank_q <= cfg_wdata[BANK_W-1:0];
         end else if (sel_perm) begin
            perm_q[gidx] <= cfg_wdata;
         end else begin
            base_q[gidx] <= cfg_wdata;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (is_ctrl) begin
         cfg_rdata[CTRL_EN_BIT]  = en_q;
         cfg_rdata[BANK_W-1:0]   = bank_q;
      end else if (sel_perm) begin
         cfg_rdata = perm_q[gidx];
      end else begin
         cfg_rdata = base_q[gidx];
      end
   end

   p_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && is_ctrl) |=> (bank_q == $past(cfg_wdata[BANK_W-1:0])))
      else $error("control write did not set bank field");
endmodule

// File: rtl/mpr_region_match.sv
module mpr_region_match #(
   parameter int AW   = 32,
   parameter int NREG = 32
) (
   input  logic                    en,
   input  logic [AW-1:0]           addr,
   input  logic [NREG-1:0][AW-1:0] base_q,
   input  logic [NREG-1:0][AW-1:0] perm_q,
   output logic [NREG-1:0]         match_vec
);
   import mpr_pkg::*;

   for (genvar gi = 0; gi < NREG; gi++) begin : g_region
      logic [4:0]    code;
      logic [4:0]    code_eff;
      logic [AW-1:0] keep;

      assign code     = {perm_q[gi][11:9], perm_q[gi][1:0]};
      assign code_eff = (code < 5'(SIZE_CODE_MIN)) ? 5'(SIZE_CODE_MIN) : code;

      always_comb begin
         for (int b = 0; b < AW; b++) begin
            keep[b] = (b > int'(code_eff));
         end
      end

      assign match_vec[gi] = en && base_q[gi][BASE_VALID_BIT] &&
                             (((addr ^ base_q[gi]) & keep) == '0);
   end
endmodule

// File: rtl/mpr_prio_select.sv
module mpr_prio_select #(
   parameter int NREG  = 32,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  match_vec,
   output logic             any_hit,
   output logic [IDX_W-1:0] win_idx
);
   always_comb begin
      win_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (match_vec[i]) win_idx = IDX_W'(i);
      end
   end

   assign any_hit = |match_vec;
endmodule

// File: rtl/mpr_region_guard.sv
module mpr_region_guard #(
   parameter int AW        = 32,
   parameter int SLOTS     = 16,
   parameter int NUM_BANKS = 2,
   localparam int NREG     = SLOTS * NUM_BANKS,
   localparam int IDX_W    = $clog2(NREG),
   localparam int CFG_AW   = $clog2(SLOTS) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [AW-1:0]     cfg_wdata,
   output logic [AW-1:0]     cfg_rdata,
   input  logic              acc_req,
   input  logic [AW-1:0]     acc_addr,
   input  logic              acc_user,
   input  logic              acc_write,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_region,
   output logic              res_allow,
   output logic              res_nc_code,
   output logic              res_nc_data,
   output logic              res_nv
);
   import mpr_pkg::*;

   if (AW < 32) begin : g_bad_aw
      $error("AW must be at least 32 for the control word layout");
   end
   if ((SLOTS & (SLOTS - 1)) != 0 || SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end

   logic [NREG-1:0][AW-1:0] base_q;
   logic [NREG-1:0][AW-1:0] perm_q;
   logic                    en_q;
   logic [NREG-1:0]         match_vec;
   logic                    any_hit;
   logic [IDX_W-1:0]        win_idx;
   logic [AW-1:0]           win_perm;
   mpr_verdict_t            vd;

   mpr_desc_store #(.AW(AW), .SLOTS(SLOTS), .NUM_BANKS(NUM_BANKS)) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .base_q(base_q), .perm_q(perm_q), .en_q(en_q));

   mpr_region_match #(.AW(AW), .NREG(NREG)) u_match (
      .en(en_q), .addr(acc_addr), .base_q(base_q), .perm_q(perm_q),
      .match_vec(match_vec));

   mpr_prio_select #(.NREG(NREG)) u_prio (
      .match_vec(match_vec), .any_hit(any_hit), .win_idx(win_idx));

   assign win_perm = perm_q[win_idx];

   always_comb begin
      vd = '0;
      if (any_hit) begin
         vd.hit     = 1'b1;
         vd.nc_code = win_perm[PERM_NCC_BIT];
         vd.nc_data = win_perm[PERM_NCD_BIT];
         vd.nv      = win_perm[PERM_NV_BIT];
         if (acc_user) vd.allow = acc_write ? win_perm[PERM_UW_BIT] : win_perm[PERM_UR_BIT];
         else          vd.allow = acc_write ? win_perm[PERM_KW_BIT] : win_perm[PERM_KR_BIT];
      end else begin
         vd.allow = !acc_user;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_hit     <= 1'b0;
         res_region  <= '0;
         res_allow   <= 1'b0;
         res_nc_code <= 1'b0;
         res_nc_data <= 1'b0;
         res_nv      <= 1'b0;
      end else begin
         res_valid <= acc_req;
         if (acc_req) begin
            res_hit     <= vd.hit;
            res_region  <= any_hit ? win_idx : '0;
            res_allow   <= vd.allow;
            res_nc_code <= vd.nc_code;
            res_nc_data <= vd.nc_data;
            res_nv      <= vd.nv;
         end
      end
   end

   p_resp_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |=> res_valid) else $error("result valid missing");
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> !res_valid) else $error("spurious result valid");
   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !en_q) |=> !res_hit) else $error("hit while disabled");
   p_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_allow == !$past(acc_user)))
      else $error("miss policy violated");
   p_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |->
         ((($past(match_vec) >> res_region) & NREG'(1)) == NREG'(1) &&
          ($past(match_vec) & ((NREG'(1) << res_region) - NREG'(1))) == '0))
      else $error("reported region not the lowest match");
endmodule

// File: tb/mpr_region_guard_tb.sv
`timescale 1ns/1ps
module mpr_region_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        acc_req = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_user = 1'b0;
   logic        acc_write = 1'b0;
   logic        res_valid, res_hit, res_allow, res_nc_code, res_nc_data, res_nv;
   logic [4:0]  res_region;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_base [32];
   logic [31:0] m_perm [32];
   logic        m_bank = 1'b0;
   logic        m_en = 1'b0;

   always #2.5 clk = ~clk;

   mpr_region_guard u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_req(acc_req),
      .acc_addr(acc_addr), .acc_user(acc_user), .acc_write(acc_write),
      .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region),
      .res_allow(res_allow), .res_nc_code(res_nc_code),
      .res_nc_data(res_nc_data), .res_nv(res_nv));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit m_match(int i, logic [31:0] a);
      int n;
      n = {m_perm[i][11:9], m_perm[i][1:0]};
      if (n < 4) n = 4;
      if (!m_base[i][0]) return 1'b0;
      if (n == 31) return 1'b1;
      return (a >> (n + 1)) == (m_base[i] >> (n + 1));
   endfunction

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a[5]) begin m_bank = d[0]; m_en = d[30]; end
      else if (a[0]) m_perm[{m_bank, a[4:1]}] = d;
      else m_base[{m_bank, a[4:1]}] = d;
   endtask

   task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
      cfg_addr = a;
      #1;
      chk(req, cfg_rdata, exp);
   endtask

   task automatic acc(string req, logic [31:0] a, logic u, logic w);
      int win;
      logic [31:0] p;
      logic ex_allow;
      win = -1;
      if (m_en) for (int i = 31; i >= 0; i--) if (m_match(i, a)) win = i;
      @(negedge clk);
      acc_req = 1'b1; acc_addr = a; acc_user = u; acc_write = w;
      @(negedge clk);
      acc_req = 1'b0;
      chk({req, " valid"}, 32'(res_valid), 32'd1);
      if (win < 0) begin
         chk({req, " hit"}, 32'(res_hit), 32'd0);
         chk({req, " region"}, 32'(res_region), 32'd0);
         chk({req, " allow"}, 32'(res_allow), 32'(!u));
         chk({req, " flags"}, {res_nc_code, res_nc_data, res_nv}, 32'd0);
      end else begin
         p = m_perm[win];
         ex_allow = u ? (w ? p[4] : p[5]) : (w ? p[7] : p[8]);
         chk({req, " hit"}, 32'(res_hit), 32'd1);
         chk({req, " region"}, 32'(res_region), 32'(win));
         chk({req, " allow"}, 32'(res_allow), 32'(ex_allow));
         chk({req, " flags"}, {res_nc_code, res_nc_data, res_nv}, {p[12], p[13], p[14]});
      end
   endtask

   function automatic logic [31:0] mk_perm(int code, logic [5:0] attr, logic [2:0] fl);
      logic [31:0] p;
      p = '0;
      p[1:0] = 2'(code); p[11:9] = 3'(code >> 2);
      p[8:3] = attr; p[14:12] = fl;
      return p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin m_base[i] = '0; m_perm[i] = '0; end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11 res_valid", 32'(res_valid), 0);
      chk("R11 res_hit", 32'(res_hit), 0);
      rd_chk("R11 ctrl", 6'd32, 32'd0);
      rd_chk("R11 base0", 6'd0, 32'd0);
      rd_chk("R11 perm7", 6'd15, 32'd0);
      // R10: no request, no valid
      @(negedge clk);
      chk("R10 idle", 32'(res_valid), 0);

      // R7/R8: region covering all, checking off
      wr(6'd0, 32'h1);
      wr(6'd1, mk_perm(31, 6'h3F, 3'b111));
      acc("R7 disabled kernel", 32'h1234_5678, 0, 0);
      acc("R8 disabled user", 32'h1234_5678, 1, 1);
      wr(6'd32, 32'h4000_0000);
      rd_chk("R1 ctrl readback", 6'd32, 32'h4000_0000);
      acc("R3 code31 whole space", 32'hFFFF_FFF0, 1, 0);
      wr(6'd0, 32'h0);  // R4: valid clear
      acc("R4 invalid never matches", 32'h1234_5678, 1, 0);

      // R3/R4: 32-byte region at 0x1000 in slot 5
      wr(6'd10, 32'h0000_1001);
      wr(6'd11, mk_perm(4, 6'b100100, 3'b101));
      rd_chk("R1 base readback", 6'd10, 32'h0000_1001);
      rd_chk("R1 perm readback", 6'd11, mk_perm(4, 6'b100100, 3'b101));
      acc("R4 low edge", 32'h0000_1000, 1, 0);
      acc("R3 high edge", 32'h0000_101F, 0, 0);
      acc("R3 just past", 32'h0000_1020, 0, 0);
      acc("R4 below base", 32'h0000_0FFF, 1, 0);
      // R3: reserved code 0 acts as 32 bytes
      wr(6'd11, mk_perm(0, 6'b100100, 3'b000));
      acc("R3 reserved inside", 32'h0000_101C, 1, 0);
      acc("R3 reserved outside", 32'h0000_1020, 1, 0);
      // R5: slot 3 overlapping, 4 KB at 0x1000 with unaligned base bits
      wr(6'd6, 32'h0000_1FE1);
      wr(6'd7, mk_perm(11, 6'b010010, 3'b010));
      acc("R5 overlap low index wins", 32'h0000_1004, 1, 1);
      acc("R5 only larger", 32'h0000_1800, 0, 1);
      // R6: each permission bit alone, exec bits ignored
      for (int b = 0; b < 6; b++) begin
         wr(6'd7, mk_perm(11, 6'(1 << b), 3'b000));
         for (int k = 0; k < 4; k++) acc("R6 perm bit", 32'h0000_1100, k[1], k[0]);
      end
      // R9: flags
      wr(6'd7, mk_perm(11, 6'h00, 3'b011));
      acc("R9 flags", 32'h0000_1100, 0, 0);
      // R2: bank 1 slot 2 is global 18
      wr(6'd32, 32'h4000_0001);
      wr(6'd4, 32'h0008_0001);
      wr(6'd5, mk_perm(14, 6'b110110, 3'b100));
      rd_chk("R2 bank1 slot2", 6'd4, 32'h0008_0001);
      acc("R2 global index 18", 32'h0008_7FFF, 1, 0);
      wr(6'd32, 32'h4000_0000);
      rd_chk("R2 bank0 slot2 untouched", 6'd4, 32'h0);
      acc("R2 bank0 view still sees 18", 32'h0008_0040, 0, 1);

      // random descriptors and accesses
      for (int it = 0; it < 40; it++) begin
         logic [31:0] bs;
         int code;
         code = $urandom_range(0, 24);
         bs = $urandom & 32'h0FFF_FFE0;
         bs[0] = ($urandom_range(0, 3) != 0);
         wr(6'd32, {1'b0, ($urandom_range(0, 7) != 0), 29'd0, 1'($urandom)});
         wr({1'b0, 4'($urandom), 1'b0}, bs);
         wr({1'b0, 4'($urandom), 1'b1}, mk_perm(code, 6'($urandom), 3'($urandom)));
         for (int j = 0; j < 25; j++) begin
            int r;
            logic [31:0] a;
            r = $urandom_range(0, 31);
            a = (m_base[r] & 32'hFFFF_FFE0) + ($urandom & 32'h0000_1FFF);
            if ($urandom_range(0, 4) == 0) a = $urandom;
            acc("R5 random", a, 1'($urandom), 1'($urandom));
         end
      end
      @(negedge clk);
      chk("R10 idle end", 32'(res_valid), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule